// File: doc/BRIEF.md
# Buffered Flash Program Sequencer

This block runs one buffered program operation against a parallel flash device from the host side. A caller gives it a block address, a start address inside that block, a word count and a flag that marks the last operation of a batch. The block first asks the device for its internal write buffer and keeps asking until the buffer is free or a cycle budget runs out. It then writes the count word and the payload and confirms the program. Finally it polls the device until the device is idle and returns one result code.

The block fetches payload words from the caller through an index/data pair: it presents the word index on `src_idx` and reads `src_data` in the same cycle. Every device access uses a synchronous request/acknowledge bus. The block holds a request with its address, direction and data until it sees an acknowledge, and read data must be valid in the acknowledge cycle. The caller chains several buffers by starting the block again. It sets `final_op` only on the last one, so that the device returns to array-read mode.

Top module: `bufprog_seq`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done` and `bus_req` are 0.
- R2: The block rejects a start request and runs no bus cycle when the count is 0, the count exceeds BUF_WORDS (16), the start address lies in a different block (blocks are 2^BLK_BITS = 256 words, address bits [23:8]), or start offset plus count exceeds the block end. In that case `done` rises in the cycle after the start and `result` is 2.
- R3: An accepted request begins with a write of 0x00E8 to the block address, followed by a read at the block address. If bit 7 of that read is 1, the block proceeds to the count word.
- R4: If bit 7 of that read is 0, the write and read repeat. When TIMEOUT_CYC (64) cycles have passed since the start and such a read returns 0, the block ends with `result` 1 and issues no further bus cycle.
- R5: The count word, written to the block address, is the word count minus one.
- R6: The payload word with index i (0 to count-1) is written to start address + i, with `src_idx` = i and data taken from `src_data`.
- R7: After the payload the block writes 0x00D0 to the block address. It then reads the block address until bit 7 of the read is 1.
- R8: If the read that completes the poll has any of bits 5, 4, 3 or 1 set, the block writes 0x0050 to the block address and ends with `result` 3.
- R9: With `final_op` set, the last bus cycle is a write of 0x00FF to the block address (after the 0x0050 write on error). Without it, no 0x00FF write occurs.
- R10: `done` is a one-cycle pulse that carries `result` (0 = success). `busy` is high from the cycle after an accepted start until the done cycle.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_addr` and `bus_we` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled in idle |
| final_op | input | 1 | Last operation of a batch: restore array-read mode at the end |
| blk_addr | input | 24 | Block address for command cycles |
| dest_addr | input | 24 | Address of the first payload word |
| word_cnt | input | 5 | Number of payload words |
| src_idx | output | 4 | Index of the payload word being fetched |
| src_data | input | 16 | Payload word for `src_idx` |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | 24 | Bus cycle address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Completes the pending bus cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 rejected, 3 device error |

## Verification
The hardest case to reach is the timeout. It needs a device that refuses the buffer on every poll for the whole budget, so that the expiry lands on a poll that has just failed. The bench's device model switches to a mode in which every availability read returns 0. It checks that the setup writes and reads alternate, and that completion comes no earlier than the budget and only a few cycles after it. The retry path without a timeout is reached by scripting two refusals before a grant. Acknowledge delays of zero to two cycles exercise the request hold.

// File: rtl/bufprog_pkg.sv
package bufprog_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XSR,
    ST_COUNT,
    ST_DATA,
    ST_CONFIRM,
    ST_POLL,
    ST_CLEAR,
    ST_RDARR,
    ST_DONE
  } seq_state_t;

  localparam logic [1:0] RES_OK      = 2'd0;
  localparam logic [1:0] RES_TIMEOUT = 2'd1;
  localparam logic [1:0] RES_REJECT  = 2'd2;
  localparam logic [1:0] RES_DEVERR  = 2'd3;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_READARR = 8'hFF;

  localparam int READY_BIT = 7;

endpackage

// File: rtl/bufprog_span_chk.sv
module bufprog_span_chk #(
  parameter int AW        = 24,
  parameter int BLK_BITS  = 8,
  parameter int BUF_WORDS = 16,
  parameter int CW        = 5
) (
  input  logic [AW-1:0] blk_addr,
  input  logic [AW-1:0] dest_addr,
  input  logic [CW-1:0] word_cnt,
  output logic          span_ok
);

  localparam int             OW       = BLK_BITS + 1;
  localparam logic [AW-1:0]  LOW_MASK = (AW'(1) << BLK_BITS) - AW'(1);
  localparam logic [OW-1:0]  BLK_SIZE = OW'(1) << BLK_BITS;

  logic          same_blk;
  logic          cnt_ok;
  logic          fits;
  logic [OW-1:0] end_off;

  always_comb begin
    same_blk = (blk_addr & ~LOW_MASK) == (dest_addr & ~LOW_MASK);
    cnt_ok   = (word_cnt != '0) && (word_cnt <= CW'(BUF_WORDS));
    end_off  = {1'b0, dest_addr[BLK_BITS-1:0]} + OW'(word_cnt);
    fits     = end_off <= BLK_SIZE;
    span_ok  = same_blk && cnt_ok && fits;
  end

endmodule

// File: rtl/bufprog_tmo_timer.sv
module bufprog_tmo_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  assign expired = (cnt_q == TW'(LIMIT));

  always_comb begin
    cnt_en = clr || !expired;
    cnt_d  = clr ? '0 : cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // once the budget is used up it stays used up until cleared (R4)
  assert_tmo_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !clr) |=> expired);

endmodule

// File: rtl/bufprog_cmd_gen.sv
module bufprog_cmd_gen
  import bufprog_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 5,
  parameter int IW = 4
) (
  input  seq_state_t    st,
  input  logic [AW-1:0] blk,
  input  logic [AW-1:0] dest,
  input  logic [CW-1:0] cnt,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] src_data,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);

  always_comb begin
    req   = 1'b1;
    we    = 1'b1;
    addr  = blk;
    wdata = '0;
    unique case (st)
      ST_SETUP:   wdata = DW'(CMD_SETUP);
      ST_XSR:     we    = 1'b0;
      ST_COUNT:   wdata = DW'(cnt - CW'(1));
      ST_DATA: begin
        addr  = dest + AW'(idx);
        wdata = src_data;
      end
      ST_CONFIRM: wdata = DW'(CMD_CONFIRM);
      ST_POLL:    we    = 1'b0;
      ST_CLEAR:   wdata = DW'(CMD_CLRSTAT);
      ST_RDARR:   wdata = DW'(CMD_READARR);
      default: begin
        req = 1'b0;
        we  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bufprog_seq.sv
module bufprog_seq
  import bufprog_pkg::*;
#(
  parameter int          AW          = 24,
  parameter int          DW          = 16,
  parameter int          BUF_WORDS   = 16,
  parameter int          BLK_BITS    = 8,
  parameter int          TIMEOUT_CYC = 64,
  parameter logic [15:0] ERR_MASK    = 16'h003A,
  localparam int         CW          = $clog2(BUF_WORDS + 1),
  localparam int         IW          = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          final_op,
  input  logic [AW-1:0] blk_addr,
  input  logic [AW-1:0] dest_addr,
  input  logic [CW-1:0] word_cnt,
  output logic [IW-1:0] src_idx,
  input  logic [DW-1:0] src_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);

  localparam logic [DW-1:0] ERR_MASK_W = DW'(ERR_MASK);

  seq_state_t    st_q, st_d;
  logic [1:0]    res_q, res_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] blk_q, dest_q;
  logic [CW-1:0] cnt_q;
  logic          final_q;
  logic          accept;
  logic          span_ok;
  logic          tmo_exp;
  logic          xfer;
  logic          rd_ready;
  logic          rd_err;

  bufprog_span_chk #(
    .AW(AW), .BLK_BITS(BLK_BITS), .BUF_WORDS(BUF_WORDS), .CW(CW)
  ) u_span (
    .blk_addr (blk_addr),
    .dest_addr(dest_addr),
    .word_cnt (word_cnt),
    .span_ok  (span_ok)
  );

  bufprog_tmo_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st_q == ST_IDLE),
    .expired(tmo_exp)
  );

  bufprog_cmd_gen #(.AW(AW), .DW(DW), .CW(CW), .IW(IW)) u_cmd (
    .st      (st_q),
    .blk     (blk_q),
    .dest    (dest_q),
    .cnt     (cnt_q),
    .idx     (idx_q),
    .src_data(src_data),
    .req     (bus_req),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata)
  );

  assign accept   = (st_q == ST_IDLE) && start;
  assign xfer     = bus_req && bus_ack;
  assign rd_ready = bus_rdata[READY_BIT];
  assign rd_err   = |(bus_rdata & ERR_MASK_W);
  assign src_idx  = idx_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign result   = res_q;

  // next-state process
  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (span_ok) begin
            st_d = ST_SETUP;
          end else begin
            res_d = RES_REJECT;
            st_d  = ST_DONE;
          end
        end
      end
      ST_SETUP: if (xfer) st_d = ST_XSR;
      ST_XSR: begin
        if (xfer) begin
          if (rd_ready) begin
            st_d = ST_COUNT;
          end else if (tmo_exp) begin
            res_d = RES_TIMEOUT;
            st_d  = ST_DONE;
          end else begin
            st_d = ST_SETUP;
          end
        end
      end
      ST_COUNT: begin
        if (xfer) begin
          idx_d = '0;
          st_d  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (xfer) begin
          if (CW'(idx_q) == cnt_q - CW'(1)) st_d = ST_CONFIRM;
          else                              idx_d = idx_q + IW'(1);
        end
      end
      ST_CONFIRM: if (xfer) st_d = ST_POLL;
      ST_POLL: begin
        if (xfer && rd_ready) begin
          if (rd_err) begin
            res_d = RES_DEVERR;
            st_d  = ST_CLEAR;
          end else begin
            res_d = RES_OK;
            st_d  = final_q ? ST_RDARR : ST_DONE;
          end
        end
      end
      ST_CLEAR: if (xfer) st_d = final_q ? ST_RDARR : ST_DONE;
      ST_RDARR: if (xfer) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      res_q <= RES_OK;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
      idx_q <= idx_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      dest_q  <= '0;
      cnt_q   <= '0;
      final_q <= 1'b0;
    end else if (accept) begin
      blk_q   <= blk_addr;
      dest_q  <= dest_addr;
      cnt_q   <= word_cnt;
      final_q <= final_op;
    end
  end

  assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !span_ok) |=> (done && result == RES_REJECT && !bus_req));

  assert_timeout_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_TIMEOUT) |-> tmo_exp);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && span_ok) |=> (busy && bus_req));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !done));

endmodule

// File: tb/bufprog_seq_test.sv
module bufprog_seq_test;

  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        final_op = 1'b0;
  logic [23:0] blk_addr = '0;
  logic [23:0] dest_addr = '0;
  logic [4:0]  word_cnt = '0;
  logic [3:0]  src_idx;
  logic [15:0] src_data;
  logic        bus_req, bus_we;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        busy, done;
  logic [1:0]  result;

  logic [15:0] pat_base = 16'h1000;
  assign src_data = pat_base + 16'(src_idx) * 16'h0111;

  always #10 clk = ~clk;

  bufprog_seq #(.TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .final_op(final_op),
    .blk_addr(blk_addr), .dest_addr(dest_addr), .word_cnt(word_cnt),
    .src_idx(src_idx), .src_data(src_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .done(done), .result(result)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int done_cnt = 0;
  int start_cyc = 0;
  int ack_delay = 0;
  int wcnt = 0;
  bit tmo_mode = 0;
  bit tmo_want_rd = 0;
  bit hold_pend = 0;
  logic [23:0] hold_addr;
  logic        hold_we;
  logic [1:0]  exp_res = 0;

  // scoreboard queues
  logic        q_we[$];
  logic [23:0] q_addr[$];
  logic [15:0] q_data[$];
  string       q_tag[$];
  logic [15:0] rd_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_w(input logic [23:0] a, input logic [15:0] d, input string t);
    q_we.push_back(1'b1); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic push_r(input logic [23:0] a, input string t);
    q_we.push_back(1'b0); q_addr.push_back(a); q_data.push_back('0); q_tag.push_back(t);
  endtask

  // driver: expected transaction list of one accepted program operation
  task automatic expect_prog(input logic [23:0] blk, input logic [23:0] dst,
                             input int n, input int refusals, input int polls,
                             input bit err, input bit fin);
    for (int k = 0; k <= refusals; k++) begin
      push_w(blk, 16'h00E8, "R3");
      push_r(blk, "R3");
    end
    push_w(blk, 16'(n - 1), "R5");
    for (int i = 0; i < n; i++) push_w(dst + 24'(i), pat_base + 16'(i) * 16'h0111, "R6");
    push_w(blk, 16'h00D0, "R7");
    for (int p = 0; p < polls; p++) push_r(blk, "R7");
    if (err) push_w(blk, 16'h0050, "R8");
    if (fin) push_w(blk, 16'h00FF, "R9");
  endtask

  // device model and monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (bus_req) begin
        if (hold_pend)
          check(bus_addr == hold_addr && bus_we == hold_we, "R11", "held request",
                {7'd0, bus_we, bus_addr}, {7'd0, hold_we, hold_addr});
        if (wcnt == ack_delay) begin
          bus_ack = 1'b1;
          wcnt = 0;
          hold_pend = 0;
          if (tmo_mode) begin
            check(bus_we == !tmo_want_rd && bus_addr == blk_addr &&
                  (tmo_want_rd || bus_wdata == 16'h00E8), "R4", "retry cycle",
                  {bus_we, bus_addr[14:0], bus_wdata}, {!tmo_want_rd, blk_addr[14:0], 16'h00E8});
            tmo_want_rd = !tmo_want_rd;
            bus_rdata = 16'h0000;
          end else if (q_we.size() == 0) begin
            check(1'b0, "R9", "unexpected bus cycle", {bus_we, bus_addr[14:0], bus_wdata}, 32'h0);
          end else begin
            automatic logic        ew = q_we.pop_front();
            automatic logic [23:0] ea = q_addr.pop_front();
            automatic logic [15:0] ed = q_data.pop_front();
            automatic string       et = q_tag.pop_front();
            check(bus_we == ew && bus_addr == ea && (!ew || bus_wdata == ed), et, "bus cycle",
                  {bus_we, bus_addr[14:0], bus_wdata}, {ew, ea[14:0], ed});
            if (!bus_we) bus_rdata = (rd_q.size() > 0) ? rd_q.pop_front() : 16'h0080;
          end
        end else begin
          bus_ack = 1'b0;
          wcnt++;
          hold_pend = 1;
          hold_addr = bus_addr;
          hold_we = bus_we;
        end
      end else begin
        bus_ack = 1'b0;
        wcnt = 0;
        hold_pend = 0;
      end
      if (done) begin
        check(result == exp_res, "R10", "result code", 32'(result), 32'(exp_res));
        check(q_we.size() == 0, "R10", "cycles left at done", q_we.size(), 0);
        if (tmo_mode)
          check(cyc - start_cyc >= TMO && cyc - start_cyc <= TMO + 8, "R4",
                "timeout latency", cyc - start_cyc, TMO);
        done_cnt++;
      end
    end
  end

  task automatic run(input logic [23:0] blk, input logic [23:0] dst, input int n,
                     input bit fin, input logic [1:0] res);
    int d0;
    @(negedge clk);
    d0 = done_cnt;
    exp_res = res;
    blk_addr = blk; dest_addr = dst; word_cnt = 5'(n); final_op = fin;
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (res == 2'd2) begin
      check(done == 1'b1 && bus_req == 1'b0, "R2", "reject timing",
            {done, bus_req}, 2'b10);
    end else begin
      check(busy == 1'b1, "R10", "busy after start", 32'(busy), 1);
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && bus_req == 0, "R1", "in reset", {busy, done, bus_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && bus_req == 0, "R1", "after reset", {busy, done, bus_req}, 0);

    // plain program, no final: R3 R5 R6 R7, no 0xFF (R9)
    ack_delay = 0; pat_base = 16'h1000;
    rd_q.push_back(16'h0080); rd_q.push_back(16'h0000); rd_q.push_back(16'h0080);
    expect_prog(24'h000100, 24'h000110, 4, 0, 2, 0, 0);
    run(24'h000100, 24'h000110, 4, 0, 2'd0);

    // two refusals then grant, single word, final op: R4 retry, R9
    ack_delay = 1; pat_base = 16'h2200;
    rd_q.push_back(16'h0000); rd_q.push_back(16'h0000); rd_q.push_back(16'h0080);
    rd_q.push_back(16'h0080);
    expect_prog(24'h000200, 24'h0002F0, 1, 2, 1, 0, 1);
    run(24'h000200, 24'h0002F0, 1, 1, 2'd0);

    // full buffer ending on the block end, error bit 4, final op: R8 then R9
    ack_delay = 2; pat_base = 16'h3300;
    rd_q.push_back(16'h0080); rd_q.push_back(16'h0090);
    expect_prog(24'h000300, 24'h0003F0, 16, 0, 1, 1, 1);
    run(24'h000300, 24'h0003F0, 16, 1, 2'd3);

    // error bit 1, no final: R8 without R9 write
    ack_delay = 0; pat_base = 16'h4400;
    rd_q.push_back(16'h0080); rd_q.push_back(16'h0082);
    expect_prog(24'h000400, 24'h000400, 3, 0, 1, 1, 0);
    run(24'h000400, 24'h000400, 3, 0, 2'd3);

    // exact fit at block end accepted (R2 boundary)
    ack_delay = 1; pat_base = 16'h5500;
    rd_q.push_back(16'h0080); rd_q.push_back(16'h0080);
    expect_prog(24'h000100, 24'h0001F8, 8, 0, 1, 0, 0);
    run(24'h000100, 24'h0001F8, 8, 0, 2'd0);

    // rejects (R2)
    run(24'h000100, 24'h000110, 0, 0, 2'd2);
    run(24'h000100, 24'h000110, 17, 0, 2'd2);
    run(24'h000100, 24'h000210, 4, 0, 2'd2);
    run(24'h000100, 24'h0001F8, 9, 1, 2'd2);

    // timeout (R4)
    ack_delay = 0; tmo_mode = 1; tmo_want_rd = 0;
    run(24'h000500, 24'h000500, 2, 1, 2'd1);
    tmo_mode = 0;

    repeat (3) @(negedge clk);
    check(bus_req == 0, "R4", "no cycle after timeout", 32'(bus_req), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule